// File: doc/BRIEF.md
# Orderly Halt Sequencer

This block stops a script-driven SCSI/DMA controller cleanly when an interrupt is raised. It does not stop at once. When the interrupt is accepted it raises a halt request to the fetch, transfer and bus engines. It then finishes whichever activities are still in flight and must not be cut off. Only after that does it report the controller as halted. The engines themselves sit outside this block. It sees their progress only through status levels.

The activities are serviced in a fixed order: an instruction fetch, then an executing instruction, then a SCSI request/acknowledge handshake, then the synchronous offset, and last a DMA FIFO flush. Activities that are not pending are skipped. A conditional jump or call that is executing loads its target into the instruction pointer on the way out. In every other case the pointer is left as it is. The halted state is held until the host issues a restart strobe.

Top module: `halt_seq`

## Requirements
- R1: After reset, halt_req, halted, flush_req and ptr_load are all low.
- R2: An irq seen while idle raises halt_req from the next cycle. If no activity is pending at that moment, halted is high from the next cycle as well.
- R3: If fetch_busy is high when the irq is accepted, the sequencer waits until fetch_busy falls. The fetched instruction is then treated as not executed, so instr_active is not waited on.
- R4: When bus_fault is high, a fetch in progress is abandoned and not waited for.
- R5: If irq_scsi is 1 (SCSI class, 0 means DMA) and dir_to_mem is 1 and fifo_empty is 0, flush_req is high until fifo_empty rises. For a DMA-class interrupt or a read direction, flush_req stays low and data may remain in the FIFO.
- R6: A handshake in progress (hs_active high) is waited for until hs_active falls.
- R7: A nonzero sync_offset is waited for until it reaches zero.
- R8: An instruction with instr_kind 1 (transfer control) and instr_active high is waited for until instr_active falls.
- R9: An instruction with instr_kind 2 (jump/call) holds the sequencer for exactly one cycle. In that cycle ptr_load equals jump_taken and ptr_value equals jump_target. At all other times ptr_load is low, so the pointer is never rewound.
- R10: An instruction with instr_kind 0 (other) is not waited on, even if instr_active stays high.
- R11: Pending activities are finished in the order fetch, instruction, handshake, offset, flush. Each one is serviced only after the one before it is done, and halted rises on the cycle after the last one completes.
- R12: halted stays high, and irq is ignored, until a restart pulse. After the restart, halt_req and halted are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 1 | Interrupt request |
| irq_scsi | input | 1 | Interrupt class: 1 SCSI, 0 DMA |
| bus_fault | input | 1 | Bus fault during fetch |
| fetch_busy | input | 1 | Instruction fetch in progress |
| instr_active | input | 1 | Instruction execution in progress |
| instr_kind | input | 2 | 0 other, 1 transfer control, 2 jump/call |
| jump_taken | input | 1 | Jump/call condition result |
| jump_target | input | PTR_W | Jump/call target address |
| dir_to_mem | input | 1 | DMA direction is write to memory |
| fifo_empty | input | 1 | DMA FIFO holds no data |
| hs_active | input | 1 | SCSI request/acknowledge handshake begun |
| sync_offset | input | OFS_W | Outstanding synchronous offset |
| restart | input | 1 | Host restart strobe |
| halt_req | output | 1 | Halt request to sub-engines |
| flush_req | output | 1 | Request to flush DMA FIFO to memory |
| ptr_load | output | 1 | Load instruction pointer |
| ptr_value | output | PTR_W | Value to load into the pointer |
| halted | output | 1 | Controller has stopped |

## Verification
The assertions rely on one property of the engines. Once an activity is reported finished (handshake dropped, offset at zero, FIFO empty), it does not restart while a halt is in progress. The direction and the interrupt class also stay fixed for that time. The bench honours this. It sets every status level in the cycle of the interrupt and releases each one only in the cycle its stage is active, in service order, and never raises it again before the restart. Every combination of class, direction, fault, instruction kind and pending activity is swept twice, once with each stage taking one cycle and once with each stage held for two.

// File: rtl/halt_seq.sv
module halt_seq #(
  parameter int PTR_W = 16,
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             irq_scsi,
  input  logic             bus_fault,
  input  logic             fetch_busy,
  input  logic             instr_active,
  input  logic [1:0]       instr_kind,
  input  logic             jump_taken,
  input  logic [PTR_W-1:0] jump_target,
  input  logic             dir_to_mem,
  input  logic             fifo_empty,
  input  logic             hs_active,
  input  logic [OFS_W-1:0] sync_offset,
  input  logic             restart,
  output logic             halt_req,
  output logic             flush_req,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_value,
  output logic             halted
);
  localparam logic [1:0] KIND_OTHER = 2'd0;
  localparam logic [1:0] KIND_TC    = 2'd1;
  localparam logic [1:0] KIND_JUMP  = 2'd2;
  localparam int NSTAGE = 5;

  typedef enum logic [2:0] {
    IDLE, FINISH_FETCH, FINISH_INSTR, FINISH_HANDSHAKE, DRAIN_OFFSET, FLUSH, HALTED
  } st_t;

  st_t state, nxt;
  logic cls_q, fetched_q;
  logic [1:0] kind_q;
  logic [NSTAGE-1:0] need;
  logic stage_done;

  wire idle        = (state == IDLE);
  wire cls_now     = idle ? irq_scsi : cls_q;
  wire fetched_now = idle ? fetch_busy : fetched_q;

  assign need[0] = fetch_busy && !bus_fault;
  assign need[1] = instr_active && (instr_kind != KIND_OTHER) && !fetched_now;
  assign need[2] = hs_active;
  assign need[3] = (sync_offset != '0);
  assign need[4] = cls_now && dir_to_mem && !fifo_empty;

  function automatic st_t pick(input int from, input logic [NSTAGE-1:0] n);
    st_t r;
    r = HALTED;
    for (int i = NSTAGE-1; i >= 0; i--)
      if (i >= from && n[i]) r = st_t'(3'(i + 1));
    return r;
  endfunction

  always_comb begin
    case (state)
      FINISH_FETCH:     stage_done = !fetch_busy || bus_fault;
      FINISH_INSTR:     stage_done = (kind_q == KIND_JUMP) || !instr_active;
      FINISH_HANDSHAKE: stage_done = !hs_active;
      DRAIN_OFFSET:     stage_done = (sync_offset == '0);
      FLUSH:            stage_done = fifo_empty;
      default:          stage_done = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      IDLE:    if (irq) nxt = pick(0, need);
      HALTED:  if (restart) nxt = IDLE;
      default: if (stage_done) nxt = pick(int'(state), need);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cls_q     <= 1'b0;
      fetched_q <= 1'b0;
      kind_q    <= KIND_OTHER;
    end else begin
      state <= nxt;
      if (idle && irq) begin
        cls_q     <= irq_scsi;
        fetched_q <= fetch_busy;
      end
      if (state != FINISH_INSTR) kind_q <= instr_kind;
    end
  end

  assign halt_req  = !idle;
  assign halted    = (state == HALTED);
  assign flush_req = (state == FLUSH);
  assign ptr_load  = (state == FINISH_INSTR) && (kind_q == KIND_JUMP) && jump_taken;
  assign ptr_value = jump_target;

  p_irq_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_req && irq |=> halt_req);

  p_flushed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) && cls_q && dir_to_mem |-> fifo_empty);

  // R7 is covered here as well: the offset must be drained at halt.
  p_bus_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !hs_active && sync_offset == '0);

  p_ptr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> !ptr_load);

  p_ptr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |-> halt_req && !halted && !flush_req);

  p_hold_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart |=> halted);

  p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted && restart |=> !halt_req && !halted);

  p_flush_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !halted && halt_req);
endmodule

// File: tb/halt_seq_test.sv
`timescale 1ns/1ps
module halt_seq_test;
  localparam int PTR_W = 16;
  localparam int OFS_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, irq_scsi = 0, bus_fault = 0, fetch_busy = 0, instr_active = 0;
  logic [1:0] instr_kind = 0;
  logic jump_taken = 0, dir_to_mem = 0, fifo_empty = 1, hs_active = 0, restart = 0;
  logic [PTR_W-1:0] jump_target = 0;
  logic [OFS_W-1:0] sync_offset = 0;
  logic halt_req, flush_req, ptr_load, halted;
  logic [PTR_W-1:0] ptr_value;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  halt_seq #(.PTR_W(PTR_W), .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_scsi(irq_scsi), .bus_fault(bus_fault),
    .fetch_busy(fetch_busy), .instr_active(instr_active), .instr_kind(instr_kind),
    .jump_taken(jump_taken), .jump_target(jump_target), .dir_to_mem(dir_to_mem),
    .fifo_empty(fifo_empty), .hs_active(hs_active), .sync_offset(sync_offset),
    .restart(restart), .halt_req(halt_req), .flush_req(flush_req), .ptr_load(ptr_load),
    .ptr_value(ptr_value), .halted(halted));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // stage codes: 0 fetch, 1 instr, 2 handshake, 3 offset, 4 flush
  task automatic release_stage(input int s);
    case (s)
      0: fetch_busy = 0;
      1: instr_active = 0;
      2: hs_active = 0;
      3: sync_offset = 0;
      default: fifo_empty = 1;
    endcase
  endtask

  task automatic run_case(input int idx, input int hold);
    bit cls, fb, bf, ia, jt, dir, hs, of, fe;
    int kind;
    bit need [5];
    string stag [5];
    string ftag;
    cls = idx[0]; fb = idx[1]; bf = idx[2]; ia = idx[3]; jt = idx[4];
    dir = idx[5]; hs = idx[6]; of = idx[7]; fe = idx[8]; kind = idx / 512;
    need[0] = fb && !bf;
    need[1] = ia && kind != 0 && !fb;
    need[2] = hs;
    need[3] = of;
    need[4] = cls && dir && !fe;
    stag[0] = "R3"; stag[1] = (kind == 2) ? "R9" : "R8";
    stag[2] = "R6"; stag[3] = "R7"; stag[4] = "R5";
    if (!(need[0] || need[1] || need[2] || need[3] || need[4])) ftag = "R2";
    else if (fb && bf) ftag = "R4";
    else if (ia && kind == 0) ftag = "R10";
    else ftag = "R11";

    irq_scsi = cls; fetch_busy = fb; bus_fault = bf; instr_active = ia;
    instr_kind = 2'(kind); jump_taken = jt; dir_to_mem = dir; hs_active = hs;
    sync_offset = of ? OFS_W'((idx % 7) + 1) : '0; fifo_empty = fe;
    jump_target = PTR_W'(idx) ^ PTR_W'(16'hA5A5);
    irq = 1;
    @(negedge clk);
    irq = 0;
    for (int s = 0; s < 5; s++) begin
      if (need[s]) begin
        int dur;
        dur = (s == 1 && kind == 2) ? 1 : hold;
        for (int c = 0; c < dur; c++) begin
          chk(halted == 0, stag[s], "halted early", halted, 0);
          chk(halt_req == 1, "R2", "halt_req", halt_req, 1);
          chk(flush_req == (s == 4), "R5", "flush_req", flush_req, s == 4);
          chk(ptr_load == (s == 1 && kind == 2 && jt), "R9", "ptr_load",
              ptr_load, s == 1 && kind == 2 && jt);
          if (ptr_load)
            chk(ptr_value == jump_target, "R9", "ptr_value", ptr_value, jump_target);
          if (c == dur - 1) release_stage(s);
          @(negedge clk);
        end
      end
    end
    chk(halted == 1, ftag, "halted", halted, 1);
    chk(flush_req == 0 && ptr_load == 0, ftag, "strobes at halt",
        {flush_req, ptr_load}, 0);
    // R12: an interrupt while halted changes nothing
    irq = 1;
    @(negedge clk);
    irq = 0;
    chk(halted == 1, "R12", "halted after irq", halted, 1);
    restart = 1;
    @(negedge clk);
    restart = 0;
    chk(halted == 0 && halt_req == 0, "R12", "after restart", {halted, halt_req}, 0);
    fetch_busy = 0; bus_fault = 0; instr_active = 0; hs_active = 0;
    sync_offset = 0; fifo_empty = 1;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({halt_req, halted, flush_req, ptr_load} == 0, "R1", "reset outputs",
        {halt_req, halted, flush_req, ptr_load}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({halt_req, halted, flush_req, ptr_load} == 0, "R1", "idle outputs",
        {halt_req, halted, flush_req, ptr_load}, 0);
    for (int hold = 1; hold <= 2; hold++)
      for (int idx = 0; idx < 1536; idx++)
        run_case(idx, hold);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule